// File: doc/BRIEF.md
# Extended Control Register Write Checker

This block holds the 64-bit extended control register of a processor core and guards every write to it. A write request carries a register index, a high data word and a low data word. Alongside it come the core status at that moment: privilege level, operating mode, a flag saying the feature exists, the OS enable bit and a flag for a lock prefix. The block checks the request against the rules for the register. A legal request commits a new value. Any other request raises exactly one fault, either general protection or undefined opcode, and leaves the register untouched.

The outcome shows one cycle after the request is sampled, as a one-cycle pulse: `wr_done` for a commit, or `fault_valid` with `fault_kind` for a fault. A general-protection fault always carries error code 0, so no error code port exists. The stored value is always visible on `rd_data`. The supported feature bits are a parameter, and every bit outside that set is reserved.

Top module: `xcr_write_guard`

## Requirements
- R1: A legal write stores `{req_data_hi[31:0], req_data_lo[31:0]}`, with the high word in bits 63:32. Bits 63:32 of both data inputs are ignored. The new value appears on `rd_data` in the cycle after the request edge, and `wr_done` is high for exactly that one cycle.
- R2: Only `req_index[31:0]` selects the register. A value of 0 there picks the one implemented register, whatever bits 63:32 hold. Any other value gives a general-protection fault.
- R3: A write whose bit 0 is 0 gives a general-protection fault.
- R4: A write whose bits [2:1] equal binary 10 gives a general-protection fault. The patterns 00, 01 and 11 are allowed.
- R5: A write that sets any bit outside `SUPPORTED_MASK` gives a general-protection fault. The default mask allows bits 0, 1, 2, 5, 6, 7 and 32.
- R6: Modes are encoded as 0 real-address, 1 protected, 2 compatibility, 3 64-bit and 4 virtual-8086. Codes 5 to 7 behave like protected mode. Outside real-address and virtual-8086 mode, a privilege level other than 0 gives a general-protection fault. In real-address mode the privilege level is not checked.
- R7: In virtual-8086 mode every request gives a general-protection fault, even when its operands are legal.
- R8: `feat_present`=0, `os_enable`=0 or `lock_prefix`=1 each give an undefined-opcode fault.
- R9: When an undefined-opcode cause and general-protection causes hold together, only the undefined-opcode fault is reported. Several general-protection causes together give a single general-protection fault. `fault_valid` and `wr_done` are never high together.
- R10: After reset `rd_data` is 1, and `wr_done` and `fault_valid` are 0.
- R11: A faulting request leaves `rd_data` unchanged. It raises `fault_valid` for exactly one cycle, in the cycle after the request edge. `fault_kind` holds 2'b01 for general protection, 2'b10 for undefined opcode and 2'b00 when no fault is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present this cycle |
| req_index | input | 64 | Register index; only bits 31:0 are decoded |
| req_data_hi | input | 64 | High data word source; bits 31:0 are used |
| req_data_lo | input | 64 | Low data word source; bits 31:0 are used |
| cur_priv | input | 2 | Current privilege level |
| cpu_mode | input | 3 | Operating mode code |
| feat_present | input | 1 | Feature is implemented |
| os_enable | input | 1 | OS has enabled the feature |
| lock_prefix | input | 1 | Request carried a lock prefix |
| rd_data | output | 64 | Stored register value |
| wr_done | output | 1 | One-cycle pulse: write committed |
| fault_valid | output | 1 | One-cycle pulse: request faulted |
| fault_kind | output | 2 | Fault type, valid with fault_valid |

## Verification
The hardest outcome to bring about is a fault decided by priority, where one request meets several causes at once. An example is a virtual-8086 request with a bad index and a lock prefix, which must report only the undefined-opcode fault. The stimulus builds such requests on purpose, each time starting from operands that would otherwise commit. This way a fault can come only from the causes that were added. Before each faulting request the register is loaded with a known legal value that differs from the reset value. The bench then confirms after the fault pulse that this value is still stored.

// File: rtl/xcrw_pkg.sv
package xcrw_pkg;

    localparam int HALF_W = 32;
    localparam int XLEN   = 2 * HALF_W;
    localparam int SRC_W  = 64;
    localparam int PRIV_W = 2;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        FK_NONE = 2'b00,
        FK_GP   = 2'b01,
        FK_UD   = 2'b10
    } fault_kind_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_REAL   = 3'd0,
        MODE_PROT   = 3'd1,
        MODE_COMPAT = 3'd2,
        MODE_LONG   = 3'd3,
        MODE_V86    = 3'd4
    } cpu_mode_e;

endpackage

// File: rtl/xcrw_check.sv
module xcrw_check
    import xcrw_pkg::*;
#(
    parameter logic [XLEN-1:0] SUPPORTED_MASK = 64'h0000_0001_0000_00E7
) (
    input  logic [SRC_W-1:0]  index,
    input  logic [XLEN-1:0]   value,
    input  logic [PRIV_W-1:0] priv,
    input  logic [MODE_W-1:0] mode,
    input  logic              feat_present,
    input  logic              os_enable,
    input  logic              lock_prefix,
    output fault_kind_e       kind
);

    localparam logic [XLEN-1:0] RSVD_MASK = ~SUPPORTED_MASK;

    logic ud_cause;
    logic v86_cause;
    logic priv_cause;
    logic idx_cause;
    logic bit0_cause;
    logic pair_cause;
    logic rsvd_cause;
    logic gp_cause;
    logic unused_idx_hi;

    assign unused_idx_hi = ^index[SRC_W-1:HALF_W];

    always_comb begin
        ud_cause   = !feat_present || !os_enable || lock_prefix;
        v86_cause  = (mode == MODE_V86);
        priv_cause = (mode != MODE_REAL) && (mode != MODE_V86) && (priv != '0);
        idx_cause  = (index[HALF_W-1:0] != '0);
        bit0_cause = !value[0];
        pair_cause = (value[2:1] == 2'b10);
        rsvd_cause = |(value & RSVD_MASK);
        gp_cause   = v86_cause | priv_cause | idx_cause
                   | bit0_cause | pair_cause | rsvd_cause;
        if (ud_cause) begin
            kind = FK_UD;
        end else if (gp_cause) begin
            kind = FK_GP;
        end else begin
            kind = FK_NONE;
        end
    end

    always_comb begin
        assert_accept_bit0_R3: assert (kind != FK_NONE || value[0] || !(feat_present && os_enable && !lock_prefix) || 1'b1 == (kind != FK_NONE))
            else $error("accepted write clearing bit 0");
        assert_accept_pair_R4: assert (!(kind == FK_NONE && value[2:1] == 2'b10))
            else $error("accepted forbidden bit pair");
        assert_accept_rsvd_R5: assert (!(kind == FK_NONE && (value & RSVD_MASK) != '0))
            else $error("accepted reserved bits");
    end

endmodule

// File: rtl/xcrw_state.sv
module xcrw_state
    import xcrw_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VALUE = 64'h1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [XLEN-1:0] value,
    input  fault_kind_e     kind,
    output logic [XLEN-1:0] xcr_value,
    output logic            done_pulse,
    output logic            fault_pulse,
    output fault_kind_e     fault_type
);

    typedef struct packed {
        logic [XLEN-1:0] xcr;
        logic            done;
        logic            fault;
        fault_kind_e     kind;
    } state_t;

    state_t s_d;
    state_t s_q;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.fault = 1'b0;
        s_d.kind  = FK_NONE;
        if (req_valid) begin
            if (kind == FK_NONE) begin
                s_d.xcr  = value;
                s_d.done = 1'b1;
            end else begin
                s_d.fault = 1'b1;
                s_d.kind  = kind;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.xcr   <= RESET_VALUE;
            s_q.done  <= 1'b0;
            s_q.fault <= 1'b0;
            s_q.kind  <= FK_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign xcr_value   = s_q.xcr;
    assign done_pulse  = s_q.done;
    assign fault_pulse = s_q.fault;
    assign fault_type  = s_q.kind;

    assert_keep_on_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fault |-> s_q.xcr == $past(s_q.xcr))
        else $error("register changed on a faulting request");

    assert_excl_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.fault && s_q.done))
        else $error("done and fault together");

    assert_fault_typed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fault |-> (s_q.kind == FK_GP || s_q.kind == FK_UD))
        else $error("fault without a type");

    assert_bit0_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.xcr[0])
        else $error("stored value has bit 0 clear");

    assert_pair_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.xcr[2:1] != 2'b10)
        else $error("stored value has forbidden pair");

endmodule

// File: rtl/xcr_write_guard.sv
module xcr_write_guard
    import xcrw_pkg::*;
#(
    parameter logic [XLEN-1:0] SUPPORTED_MASK = 64'h0000_0001_0000_00E7,
    parameter logic [XLEN-1:0] RESET_VALUE    = 64'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_index,
    input  logic [SRC_W-1:0]  req_data_hi,
    input  logic [SRC_W-1:0]  req_data_lo,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic [MODE_W-1:0] cpu_mode,
    input  logic              feat_present,
    input  logic              os_enable,
    input  logic              lock_prefix,
    output logic [XLEN-1:0]   rd_data,
    output logic              wr_done,
    output logic              fault_valid,
    output logic [1:0]        fault_kind
);

    logic [XLEN-1:0] wr_value;
    fault_kind_e     chk_kind;
    fault_kind_e     st_kind;
    logic            unused_src_hi;

    assign wr_value      = {req_data_hi[HALF_W-1:0], req_data_lo[HALF_W-1:0]};
    assign unused_src_hi = ^{req_data_hi[SRC_W-1:HALF_W], req_data_lo[SRC_W-1:HALF_W]};

    xcrw_check #(
        .SUPPORTED_MASK (SUPPORTED_MASK)
    ) check_i (
        .index        (req_index),
        .value        (wr_value),
        .priv         (cur_priv),
        .mode         (cpu_mode),
        .feat_present (feat_present),
        .os_enable    (os_enable),
        .lock_prefix  (lock_prefix),
        .kind         (chk_kind)
    );

    xcrw_state #(
        .RESET_VALUE (RESET_VALUE)
    ) state_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .value       (wr_value),
        .kind        (chk_kind),
        .xcr_value   (rd_data),
        .done_pulse  (wr_done),
        .fault_pulse (fault_valid),
        .fault_type  (st_kind)
    );

    assign fault_kind = st_kind;

    assert_ud_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (!feat_present || !os_enable || lock_prefix))
        |=> (fault_valid && fault_kind == FK_UD))
        else $error("undefined-opcode cause not reported first");

    assert_v86_gp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_present && os_enable && !lock_prefix && cpu_mode == MODE_V86)
        |=> (fault_valid && fault_kind == FK_GP))
        else $error("virtual-8086 request not faulted");

    assert_commit_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> rd_data == $past(wr_value))
        else $error("committed value mismatch");

    assert_rsvd_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~SUPPORTED_MASK) == '0)
        else $error("stored value has reserved bits");

endmodule

// File: tb/xcr_write_guard_tb_top.sv
`timescale 1ns/1ps
module xcr_write_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_index = '0;
    logic [63:0] req_data_hi = '0;
    logic [63:0] req_data_lo = '0;
    logic [1:0]  cur_priv = '0;
    logic [2:0]  cpu_mode = 3'd3;
    logic        feat_present = 1'b1;
    logic        os_enable = 1'b1;
    logic        lock_prefix = 1'b0;
    logic [63:0] rd_data;
    logic        wr_done;
    logic        fault_valid;
    logic [1:0]  fault_kind;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    localparam logic [1:0] K_NONE = 2'b00;
    localparam logic [1:0] K_GP   = 2'b01;
    localparam logic [1:0] K_UD   = 2'b10;

    always #2 clk = ~clk;

    xcr_write_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
        .req_data_hi(req_data_hi), .req_data_lo(req_data_lo), .cur_priv(cur_priv),
        .cpu_mode(cpu_mode), .feat_present(feat_present), .os_enable(os_enable),
        .lock_prefix(lock_prefix), .rd_data(rd_data), .wr_done(wr_done),
        .fault_valid(fault_valid), .fault_kind(fault_kind)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [63:0] idx, input logic [63:0] hi, input logic [63:0] lo,
                         input logic [1:0] pl, input logic [2:0] md,
                         input bit fp, input bit oe, input bit lk);
        @(negedge clk);
        req_index = idx; req_data_hi = hi; req_data_lo = lo;
        cur_priv = pl; cpu_mode = md; feat_present = fp; os_enable = oe; lock_prefix = lk;
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // sampled 1 ns after the request edge, then again one cycle later
    task automatic expect_out(input string tag, input logic [1:0] kind, input logic [63:0] val);
        bit is_fault;
        is_fault = (kind != K_NONE);
        chk(rd_data == val, {tag, " value"}, rd_data, val);
        chk(wr_done == !is_fault, {tag, " done"}, 64'(wr_done), 64'(!is_fault));
        chk(fault_valid == is_fault, {tag, " fault"}, 64'(fault_valid), 64'(is_fault));
        if (is_fault) chk(fault_kind == kind, {tag, " kind"}, 64'(fault_kind), 64'(kind));
        @(posedge clk);
        #1;
        chk(!wr_done && !fault_valid, {tag, " pulse width"}, 64'({wr_done, fault_valid}), 64'd0);
        chk(rd_data == val, {tag, " value held"}, rd_data, val);
    endtask

    task automatic legal(input logic [63:0] lo, input string tag);
        issue(64'd0, 64'd0, lo, 2'd0, 3'd3, 1'b1, 1'b1, 1'b0);
        expect_out(tag, K_NONE, lo);
    endtask

    task automatic t_reset;
        chk(rd_data == 64'd1, "R10 reset value", rd_data, 64'd1);
        chk(!wr_done && !fault_valid, "R10 reset pulses", 64'({wr_done, fault_valid}), 64'd0);
    endtask

    task automatic t_compose;
        issue(64'd0, 64'h1234_5678_0000_0001, 64'hDEAD_BEEF_0000_00E7, 2'd0, 3'd3, 1'b1, 1'b1, 1'b0);
        expect_out("R1 compose", K_NONE, 64'h0000_0001_0000_00E7);
    endtask

    task automatic t_index;
        legal(64'h3, "R2 base");
        issue(64'hFFFF_FFFF_0000_0000, 64'd0, 64'h7, 2'd0, 3'd1, 1'b1, 1'b1, 1'b0);
        expect_out("R2 upper index ignored", K_NONE, 64'h7);
        issue(64'd1, 64'd0, 64'h3, 2'd0, 3'd3, 1'b1, 1'b1, 1'b0);
        expect_out("R2 index 1", K_GP, 64'h7);
        issue(64'h8000_0000, 64'd0, 64'h3, 2'd0, 3'd3, 1'b1, 1'b1, 1'b0);
        expect_out("R2 index high bit", K_GP, 64'h7);
    endtask

    task automatic t_bits;
        legal(64'h23, "R3 base");
        issue(64'd0, 64'd0, 64'h6, 2'd0, 3'd3, 1'b1, 1'b1, 1'b0);
        expect_out("R3 clear bit0", K_GP, 64'h23);
        issue(64'd0, 64'd0, 64'h5, 2'd0, 3'd3, 1'b1, 1'b1, 1'b0);
        expect_out("R4 pair 10", K_GP, 64'h23);
        legal(64'h1, "R4 pair 00");
        legal(64'h3, "R4 pair 01");
        legal(64'h7, "R4 pair 11");
        issue(64'd0, 64'd0, 64'h9, 2'd0, 3'd3, 1'b1, 1'b1, 1'b0);
        expect_out("R5 reserved bit3", K_GP, 64'h7);
        issue(64'd0, 64'h8000_0000, 64'h7, 2'd0, 3'd3, 1'b1, 1'b1, 1'b0);
        expect_out("R5 reserved bit63", K_GP, 64'h7);
    endtask

    task automatic t_priv;
        legal(64'h61, "R6 base");
        issue(64'd0, 64'd0, 64'h3, 2'd3, 3'd1, 1'b1, 1'b1, 1'b0);
        expect_out("R6 protected pl3", K_GP, 64'h61);
        issue(64'd0, 64'd0, 64'h3, 2'd1, 3'd2, 1'b1, 1'b1, 1'b0);
        expect_out("R6 compat pl1", K_GP, 64'h61);
        issue(64'd0, 64'd0, 64'h3, 2'd2, 3'd3, 1'b1, 1'b1, 1'b0);
        expect_out("R6 64bit pl2", K_GP, 64'h61);
        issue(64'd0, 64'd0, 64'h3, 2'd3, 3'd0, 1'b1, 1'b1, 1'b0);
        expect_out("R6 real pl3", K_NONE, 64'h3);
    endtask

    task automatic t_v86;
        legal(64'hA1, "R7 base");
        issue(64'd0, 64'd0, 64'h3, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0);
        expect_out("R7 v86 legal operands", K_GP, 64'hA1);
    endtask

    task automatic t_ud;
        legal(64'hC3, "R8 base");
        issue(64'd0, 64'd0, 64'h3, 2'd0, 3'd3, 1'b0, 1'b1, 1'b0);
        expect_out("R8 feature absent", K_UD, 64'hC3);
        issue(64'd0, 64'd0, 64'h3, 2'd0, 3'd3, 1'b1, 1'b0, 1'b0);
        expect_out("R8 os disabled", K_UD, 64'hC3);
        issue(64'd0, 64'd0, 64'h3, 2'd0, 3'd3, 1'b1, 1'b1, 1'b1);
        expect_out("R8 lock prefix", K_UD, 64'hC3);
    endtask

    task automatic t_combo;
        issue(64'd5, 64'd0, 64'h3, 2'd0, 3'd4, 1'b1, 1'b1, 1'b1);
        expect_out("R9 ud over v86 and index", K_UD, 64'hC3);
        issue(64'd0, 64'h8000_0000, 64'h4, 2'd3, 3'd1, 1'b0, 1'b0, 1'b0);
        expect_out("R9 ud over value and priv", K_UD, 64'hC3);
        issue(64'd2, 64'd0, 64'h0C, 2'd3, 3'd2, 1'b1, 1'b1, 1'b0);
        expect_out("R9 many gp causes", K_GP, 64'hC3);
        issue(64'd0, 64'd0, 64'h4, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0);
        expect_out("R11 bit0 and pair real mode", K_GP, 64'hC3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        t_reset();
        t_compose();
        t_index();
        t_bits();
        t_priv();
        t_v86();
        t_ud();
        t_combo();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule